// File: doc/BRIEF.md
# Column Output Latch with Blanking Overrides

This block sits behind a display column shift register. It holds one word of column data in a parallel storage latch, and it turns that word into the state of every column output. The shift chain presents all of its stage values in parallel on `stage_in`. An active-low load strobe copies them into the latch, and the latch keeps them until the next load. The load strobe is sampled by the block clock. A load takes place on the first rising clock edge at which the strobe reads low after it read high on the edge before. The whole design therefore stays in one clock domain.

Three global controls act on the latched word without changing it, in a fixed order of priority. A float request turns off every driver. A low-blank input pulls every column low. A high-blank input pulls every column high. When all three are released, each column drives its latched bit. Each column is reported as a level bit plus a drive-enable bit. A disabled drive stands for high impedance, and its level bit then carries no meaning.

Top module: `colatch_top`

## Requirements
- R1: While `rst` is high at a rising clock edge, the latch clears to all zeros. With no override active, every column then drives level 0.
- R2: When `load_n` is sampled low at a rising edge after being sampled high at the previous edge (or at reset), the latch takes `stage_in` at that edge. Bit i of `stage_in` feeds column i.
- R3: The latch keeps its contents at every other edge, including while `load_n` stays low over several edges.
- R4: While `hiz_req` is 1, every bit of `col_drive_en` is 0, whatever the blank inputs are.
- R5: While `hiz_req` is 0 and `blank_lo_n` is 0, every bit of `col_drive_en` is 1 and every bit of `col_data` is 0, whatever `blank_hi_n` is.
- R6: While `hiz_req` is 0, `blank_lo_n` is 1 and `blank_hi_n` is 0, every bit of `col_drive_en` is 1 and every bit of `col_data` is 1.
- R7: While `hiz_req` is 0 and both blank inputs are 1, every bit of `col_drive_en` is 1 and `col_data` equals the latched word.
- R8: The override inputs never alter the latch. A load made while an override is active takes effect, and once the overrides are released the latched word appears at once, with no clock edge needed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| stage_in | input | COLS | Parallel values from the shift stages |
| load_n | input | 1 | Active-low load strobe; a high-to-low change triggers a load |
| hiz_req | input | 1 | Float request; highest priority |
| blank_lo_n | input | 1 | Active-low force-low blank |
| blank_hi_n | input | 1 | Active-low force-high blank |
| col_data | output | COLS | Level of each column |
| col_drive_en | output | COLS | Drive enable of each column; 0 means high impedance |

## Verification
On every clock edge, the assertions check the priority mapping from the three override inputs to the output word. They also check that the latch copies its input on a detected load and stays still otherwise. Only the bench scenarios can show the rest. Those behaviours are: that a strobe held low for many cycles loads exactly once, that reset clears a previously loaded word, and that a word loaded under an override appears once the override is released. The bench sweeps all eight override combinations over several computed data patterns.

// File: rtl/colatch_pkg.sv
package colatch_pkg;

    localparam int unsigned COLS_DEFAULT = 96;

    // Resolved override state, listed by falling priority.
    typedef enum logic [1:0] {
        OVR_FLOAT    = 2'd0,
        OVR_FORCE_LO = 2'd1,
        OVR_FORCE_HI = 2'd2,
        OVR_PASS     = 2'd3
    } ovr_mode_e;

    // State of one column output.
    typedef struct packed {
        logic drive;
        logic level;
    } pin_state_t;

    function automatic ovr_mode_e pick_mode(input logic hiz,
                                            input logic lo_n,
                                            input logic hi_n);
        if (hiz)
            return OVR_FLOAT;
        else if (!lo_n)
            return OVR_FORCE_LO;
        else if (!hi_n)
            return OVR_FORCE_HI;
        else
            return OVR_PASS;
    endfunction

endpackage

// File: rtl/colatch_fall_detect.sv
module colatch_fall_detect (
    input  logic clk,
    input  logic rst,
    input  logic strobe_n,
    output logic fire
);
    // Strobe level seen at the previous edge; idles high.
    logic prev_q;

    always_ff @(posedge clk) begin
        if (rst)
            prev_q <= 1'b1;
        else
            prev_q <= strobe_n;
    end

    assign fire = prev_q & ~strobe_n;

endmodule

// File: rtl/colatch_store.sv
module colatch_store #(
    parameter int unsigned COLS = colatch_pkg::COLS_DEFAULT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic [COLS-1:0] d,
    output logic [COLS-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst)
            q <= '0;
        else if (load)
            q <= d;
    end

    // R2: a detected load copies the stage word
    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        load |=> (q == $past(d)));

    // R3 / R8: no load, no change
    assert_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(q));

endmodule

// File: rtl/colatch_drive.sv
module colatch_drive #(
    parameter int unsigned COLS = colatch_pkg::COLS_DEFAULT
) (
    input  colatch_pkg::ovr_mode_e mode,
    input  logic [COLS-1:0]        q,
    output logic [COLS-1:0]        data,
    output logic [COLS-1:0]        en
);
    import colatch_pkg::*;

    for (genvar c = 0; c < COLS; c++) begin : g_col
        pin_state_t ps;
        always_comb begin
            unique case (mode)
                OVR_FLOAT:    ps = '{drive: 1'b0, level: 1'b0};
                OVR_FORCE_LO: ps = '{drive: 1'b1, level: 1'b0};
                OVR_FORCE_HI: ps = '{drive: 1'b1, level: 1'b1};
                default:      ps = '{drive: 1'b1, level: q[c]};
            endcase
        end
        assign en[c]   = ps.drive;
        assign data[c] = ps.level;
    end

endmodule

// File: rtl/colatch_top.sv
module colatch_top #(
    parameter int unsigned COLS = colatch_pkg::COLS_DEFAULT
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [COLS-1:0] stage_in,
    input  logic            load_n,
    input  logic            hiz_req,
    input  logic            blank_lo_n,
    input  logic            blank_hi_n,
    output logic [COLS-1:0] col_data,
    output logic [COLS-1:0] col_drive_en
);
    import colatch_pkg::*;

    logic            load_fire;
    logic [COLS-1:0] latched_q;
    ovr_mode_e       mode;

    colatch_fall_detect u_edge (
        .clk      (clk),
        .rst      (rst),
        .strobe_n (load_n),
        .fire     (load_fire)
    );

    colatch_store #(.COLS(COLS)) u_store (
        .clk  (clk),
        .rst  (rst),
        .load (load_fire),
        .d    (stage_in),
        .q    (latched_q)
    );

    assign mode = pick_mode(hiz_req, blank_lo_n, blank_hi_n);

    colatch_drive #(.COLS(COLS)) u_drive (
        .mode (mode),
        .q    (latched_q),
        .data (col_data),
        .en   (col_drive_en)
    );

    // R4: float request turns every driver off
    assert_float_all_R4: assert property (@(posedge clk) disable iff (rst)
        hiz_req |-> (col_drive_en == '0));

    // R5: low blank wins over high blank
    assert_force_lo_R5: assert property (@(posedge clk) disable iff (rst)
        (!hiz_req && !blank_lo_n) |-> (col_drive_en == '1 && col_data == '0));

    // R6: high blank alone
    assert_force_hi_R6: assert property (@(posedge clk) disable iff (rst)
        (!hiz_req && blank_lo_n && !blank_hi_n) |-> (col_drive_en == '1 && col_data == '1));

    // R7: pass-through of the stored word
    assert_pass_R7: assert property (@(posedge clk) disable iff (rst)
        (!hiz_req && blank_lo_n && blank_hi_n) |-> (col_drive_en == '1 && col_data == latched_q));

endmodule

// File: tb/tb_colatch_top.sv
`timescale 1ns/1ps
module tb_colatch_top;
    localparam int W = 96;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic         rst;
    logic [W-1:0] stage_in;
    logic         load_n, hiz_req, blank_lo_n, blank_hi_n;
    logic [W-1:0] col_data, col_drive_en;

    int checks   = 0;
    int failures = 0;
    logic [W-1:0] model;

    colatch_top #(.COLS(W)) dut (
        .clk(clk), .rst(rst), .stage_in(stage_in), .load_n(load_n),
        .hiz_req(hiz_req), .blank_lo_n(blank_lo_n), .blank_hi_n(blank_hi_n),
        .col_data(col_data), .col_drive_en(col_drive_en)
    );

    function automatic logic [W-1:0] pat(input int k);
        logic [W-1:0] v;
        for (int i = 0; i < W; i++)
            v[i] = (((i * (k + 3)) + k) % 7) < 3;
        return v;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Apply one override combination and compare against the priority rule.
    task automatic try_combo(input logic hz, input logic lo_n, input logic hi_n);
        hiz_req = hz; blank_lo_n = lo_n; blank_hi_n = hi_n;
        #1;
        if (hz) begin
            chk("R4 en", col_drive_en, '0);
        end else if (!lo_n) begin
            chk("R5 en", col_drive_en, '1);
            chk("R5 data", col_data, '0);
        end else if (!hi_n) begin
            chk("R6 en", col_drive_en, '1);
            chk("R6 data", col_data, '1);
        end else begin
            chk("R7 en", col_drive_en, '1);
            chk("R7 data", col_data, model);
        end
    endtask

    task automatic sweep();
        for (int m = 0; m < 8; m++)
            try_combo(m[2], m[1], m[0]);
        try_combo(1'b0, 1'b1, 1'b1);
    endtask

    task automatic load_word(input logic [W-1:0] p);
        @(negedge clk);
        stage_in = p; load_n = 1'b0;
        @(negedge clk);
        load_n = 1'b1; stage_in = ~p;
        model = p;
        @(negedge clk);
    endtask

    initial begin
        #(20000 * 5);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        rst = 1'b1; stage_in = pat(1); load_n = 1'b1;
        hiz_req = 1'b0; blank_lo_n = 1'b1; blank_hi_n = 1'b1;
        model = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: cleared word, driven
        chk("R1 en", col_drive_en, '1);
        chk("R1 data", col_data, '0);

        // R2 + R4..R7 over several patterns
        for (int k = 0; k < 6; k++) begin
            load_word(pat(k));
            chk("R2 load", col_data, model);
            sweep();
        end
        load_word('1);
        sweep();
        load_word({W/2{2'b01}});
        chk("R2 bit order", col_data, {W/2{2'b01}});

        // R3: held while strobe high and stage values move
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            stage_in = pat(20 + i);
        end
        @(negedge clk);
        chk("R3 hold high", col_data, model);

        // R3: strobe held low loads only once
        @(negedge clk); stage_in = pat(30); load_n = 1'b0;
        @(negedge clk); stage_in = pat(31);
        @(negedge clk); stage_in = pat(32);
        @(negedge clk); load_n = 1'b1;
        model = pat(30);
        @(negedge clk);
        chk("R3 single load", col_data, model);

        // R8: load while floated, then release
        hiz_req = 1'b1;
        load_word(pat(40));
        #1;
        chk("R8 floated en", col_drive_en, '0);
        hiz_req = 1'b0; #1;
        chk("R8 release", col_data, pat(40));
        // R8: low blank with stage moving, no load
        blank_lo_n = 1'b0;
        repeat (3) begin
            @(negedge clk);
            stage_in = pat(41);
        end
        blank_lo_n = 1'b1; #1;
        chk("R8 blank release", col_data, pat(40));

        // R1: reset clears a loaded word
        @(negedge clk); rst = 1'b1;
        @(negedge clk); @(negedge clk); rst = 1'b0;
        model = '0;
        @(negedge clk);
        chk("R1 reclear", col_data, '0);
        sweep();

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule